// File: doc/BRIEF.md
# Accumulator ALU with Registered Flags

This unit is the arithmetic and logic datapath of a small 8-bit processor core. Each cycle it takes an operation code, the accumulator value, a second operand, a 3-bit bit index and the current flag byte. It produces an 8-bit result and a write-enable that tells the register file whether to store that result. The new flag byte is captured in a register on every rising clock edge.

Two-input operations (add, subtract, compare and the bitwise logic) combine the accumulator `a_i` with the operand `b_i`. Single-register operations (increment, decrement, rotates, shifts, nibble swap and bit test/set/reset) act on `b_i`, so the decoder can route any register or memory byte there. Complement and decimal adjust act on `a_i`. Decode, operand fetch and memory access belong to the surrounding core.

The flag byte has zero at bit 7, subtract at bit 6, half-carry at bit 5 and carry at bit 4. Bits 3 to 0 always read 0. Opcode encoding on `op_i`: 0 no-op, 1 add, 2 add with carry, 3 subtract, 4 subtract with carry, 5 compare, 6 AND, 7 OR, 8 XOR, 9 increment, 10 decrement, 11 complement A, 12 set carry, 13 complement carry, 14 rotate left through carry, 15 rotate left, 16 rotate right through carry, 17 rotate right, 18 shift left arithmetic, 19 shift right arithmetic, 20 shift right logical, 21 nibble swap, 22 bit test, 23 bit set, 24 bit reset, 25 decimal adjust. Codes 26 to 31 behave as the no-op.

Top module: `acc_alu`

## Requirements
- R1: `flags_o` resets to 0x00 under synchronous reset. Otherwise each rising edge loads it with the new flags, laid out Z=bit7, N=bit6, H=bit5, C=bit4, with bits 3..0 at 0. The no-op (code 0, and codes 26..31) copies `flags_i[7:4]` unchanged.
- R2: Add (1) and add-with-carry (2) return a+b (+C for code 2) mod 256. Z marks a zero result, N=0, H is the carry out of bit 3 and C is the carry out of bit 7.
- R3: Subtract (3), subtract-with-carry (4) and compare (5) compute a-b (-C for code 4) mod 256. They set N=1, H to the borrow from bit 4 and C to the borrow from bit 8, and Z marks a zero difference. Compare drives `wr_o`=0.
- R4: AND (6), OR (7) and XOR (8) return the bitwise result with C=0 and N=0. H=1 for AND and 0 for OR and XOR. Z marks a zero result.
- R5: Increment (9) and decrement (10) return b+1 or b-1 mod 256. They set Z from the result, N=1 only for decrement and H from the carry or borrow across bit 3, and they leave C unchanged.
- R6: Complement (11) returns ~a, sets N=1 and H=1, and keeps Z and C.
- R7: Set carry (12) forces C=1 and complement carry (13) inverts C. Both clear N and H, keep Z and drive `wr_o`=0.
- R8: Rotate left through carry (14) gives {b[6:0],C} and rotate right through carry (16) gives {C,b[7:1]}. Plain rotate left (15) gives {b[6:0],b[7]} and plain rotate right (17) gives {b[0],b[7:1]}. The bit shifted out goes to C, Z marks a zero result, and N=H=0.
- R9: Shift left (18) gives {b[6:0],0}, arithmetic right (19) gives {b[7],b[7:1]} and logical right (20) gives {0,b[7:1]}, with the bit shifted out in C. Swap (21) exchanges b[7:4] with b[3:0] and clears C. All four set Z from the result and N=H=0.
- R10: Bit test (22) sets Z to the inverse of b[sel_i], where bit 0 is the LSB. It sets N=0 and H=1, keeps C and drives `wr_o`=0.
- R11: Bit set (23) and bit reset (24) return b with bit sel_i forced to 1 or 0, and leave all four flags unchanged.
- R12: Decimal adjust (25) works on a. When N=0 it adds 0x60 and sets C if C was set or a>0x99, and it adds 0x06 if H was set or a[3:0]>9. When N=1 it subtracts 0x60 if C is set and 0x06 if H is set, keeping C. Z marks a zero result, H=0 and N is kept.
- R13: `wr_o` is 1 for every value-producing code and 0 for the no-op, compare, set carry, complement carry and bit test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Accumulator value |
| b_i | input | 8 | Second operand, or the target of a single-register operation |
| sel_i | input | 3 | Bit index for test, set and reset |
| flags_i | input | 8 | Current flag byte (bits 7..4 used) |
| result_o | output | 8 | Combinational result |
| wr_o | output | 1 | Result write-enable |
| flags_o | output | 8 | Registered new flag byte |

## Verification
Add-with-carry and subtract-with-carry are swept over every accumulator and operand pair. A wrong half-carry or a lost carry-in would then show up on nibble and byte boundaries such as 0x0F+0x01 and 0x00-0x01. Decimal adjust is swept over every accumulator value with all eight N/H/C combinations. Such a design would otherwise slip when the low correction pushes the high nibble past 9, or it would set carry on the subtract path. Directed cases cover compare of equal values, which must set Z while keeping `wr_o` low, and a bit test of bit 7. They also cover the no-op and unused codes, which must pass the flags through untouched, and increment from 0xFF, which must leave carry alone even though the result wraps.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DW = 8;
    localparam int NW = DW / 2;
    localparam int IW = $clog2(DW);

    typedef enum logic [4:0] {
        OP_NOP   = 5'd0,
        OP_ADD   = 5'd1,
        OP_ADC   = 5'd2,
        OP_SUB   = 5'd3,
        OP_SBC   = 5'd4,
        OP_CMP   = 5'd5,
        OP_AND   = 5'd6,
        OP_OR    = 5'd7,
        OP_XOR   = 5'd8,
        OP_INC   = 5'd9,
        OP_DEC   = 5'd10,
        OP_CPL   = 5'd11,
        OP_SCF   = 5'd12,
        OP_CCF   = 5'd13,
        OP_RLTC  = 5'd14,
        OP_RL    = 5'd15,
        OP_RRTC  = 5'd16,
        OP_RR    = 5'd17,
        OP_SHL   = 5'd18,
        OP_SHRA  = 5'd19,
        OP_SHRL  = 5'd20,
        OP_SWAP  = 5'd21,
        OP_BTST  = 5'd22,
        OP_BSET  = 5'd23,
        OP_BCLR  = 5'd24,
        OP_DADJ  = 5'd25
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ARITH = 2'd1,
        CLS_LOGIC = 2'd2,
        CLS_SHIFT = 2'd3
    } alu_cls_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] val;
        logic          wr;
        flags_t        f;
    } alu_res_t;

    function automatic flags_t flags_from_byte(logic [DW-1:0] fb);
        flags_t f;
        f.z = fb[7];
        f.n = fb[6];
        f.h = fb[5];
        f.c = fb[4];
        return f;
    endfunction

    function automatic logic [DW-1:0] flags_to_byte(flags_t f);
        return {f.z, f.n, f.h, f.c, {(DW-4){1'b0}}};
    endfunction

    function automatic alu_cls_e op_class(alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP,
            OP_INC, OP_DEC, OP_DADJ:            return CLS_ARITH;
            OP_AND, OP_OR, OP_XOR,
            OP_CPL, OP_SCF, OP_CCF:             return CLS_LOGIC;
            OP_RLTC, OP_RL, OP_RRTC, OP_RR,
            OP_SHL, OP_SHRA, OP_SHRL, OP_SWAP,
            OP_BTST, OP_BSET, OP_BCLR:          return CLS_SHIFT;
            default:                            return CLS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
(
    input  alu_op_e        op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  flags_t         fin,
    output alu_res_t       res
);

    localparam logic [DW-1:0] ADJ_LO = DW'(6);
    localparam logic [DW-1:0] ADJ_HI = DW'(8'h60);
    localparam logic [DW-1:0] DEC_MAX = DW'(8'h99);

    logic          cin;
    logic [DW:0]   wide;
    logic [NW:0]   half;
    logic [DW-1:0] adj;
    logic          adj_c;

    assign cin = ((op == OP_ADC) || (op == OP_SBC)) ? fin.c : 1'b0;

    always_comb begin
        wide = '0;
        half = '0;
        case (op)
            OP_ADD, OP_ADC: begin
                wide = {1'b0, a} + {1'b0, b} + (DW+1)'(cin);
                half = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + (NW+1)'(cin);
            end
            OP_SUB, OP_SBC, OP_CMP: begin
                wide = {1'b0, a} - {1'b0, b} - (DW+1)'(cin);
                half = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - (NW+1)'(cin);
            end
            OP_INC: begin
                wide = {1'b0, b} + (DW+1)'(1);
                half = {1'b0, b[NW-1:0]} + (NW+1)'(1);
            end
            OP_DEC: begin
                wide = {1'b0, b} - (DW+1)'(1);
                half = {1'b0, b[NW-1:0]} - (NW+1)'(1);
            end
            default: ;
        endcase
    end

    always_comb begin
        adj   = a;
        adj_c = fin.c;
        if (!fin.n) begin
            if (fin.c || (a > DEC_MAX)) begin
                adj   = adj + ADJ_HI;
                adj_c = 1'b1;
            end
            if (fin.h || (a[NW-1:0] > NW'(9))) begin
                adj = adj + ADJ_LO;
            end
        end else begin
            if (fin.c) adj = adj - ADJ_HI;
            if (fin.h) adj = adj - ADJ_LO;
        end
    end

    always_comb begin
        res.val = a;
        res.wr  = 1'b0;
        res.f   = fin;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
                res.val = wide[DW-1:0];
                res.wr  = (op != OP_CMP);
                res.f.z = (wide[DW-1:0] == '0);
                res.f.n = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
                res.f.h = half[NW];
                res.f.c = wide[DW];
            end
            OP_INC, OP_DEC: begin
                res.val = wide[DW-1:0];
                res.wr  = 1'b1;
                res.f.z = (wide[DW-1:0] == '0);
                res.f.n = (op == OP_DEC);
                res.f.h = half[NW];
            end
            OP_DADJ: begin
                res.val = adj;
                res.wr  = 1'b1;
                res.f.z = (adj == '0);
                res.f.h = 1'b0;
                res.f.c = adj_c;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
(
    input  alu_op_e        op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  flags_t         fin,
    output alu_res_t       res
);

    logic [DW-1:0] bw;

    always_comb begin
        case (op)
            OP_AND:  bw = a & b;
            OP_OR:   bw = a | b;
            OP_XOR:  bw = a ^ b;
            default: bw = ~a;
        endcase
    end

    always_comb begin
        res.val = a;
        res.wr  = 1'b0;
        res.f   = fin;
        case (op)
            OP_AND, OP_OR, OP_XOR: begin
                res.val = bw;
                res.wr  = 1'b1;
                res.f   = '{z: (bw == '0), n: 1'b0, h: (op == OP_AND), c: 1'b0};
            end
            OP_CPL: begin
                res.val = bw;
                res.wr  = 1'b1;
                res.f.n = 1'b1;
                res.f.h = 1'b1;
            end
            OP_SCF, OP_CCF: begin
                res.f.n = 1'b0;
                res.f.h = 1'b0;
                res.f.c = (op == OP_SCF) ? 1'b1 : ~fin.c;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
(
    input  alu_op_e        op,
    input  logic [DW-1:0]  b,
    input  logic [IW-1:0]  sel,
    input  flags_t         fin,
    output alu_res_t       res
);

    logic [DW-1:0] mask;
    logic [DW-1:0] sv;
    logic          sc;

    genvar gi;
    generate
        for (gi = 0; gi < DW; gi++) begin : g_mask
            assign mask[gi] = (sel == IW'(gi));
        end
    endgenerate

    always_comb begin
        sv = b;
        sc = 1'b0;
        case (op)
            OP_RLTC: begin sv = {b[DW-2:0], fin.c};       sc = b[DW-1]; end
            OP_RL:   begin sv = {b[DW-2:0], b[DW-1]};     sc = b[DW-1]; end
            OP_RRTC: begin sv = {fin.c, b[DW-1:1]};       sc = b[0];    end
            OP_RR:   begin sv = {b[0], b[DW-1:1]};        sc = b[0];    end
            OP_SHL:  begin sv = {b[DW-2:0], 1'b0};        sc = b[DW-1]; end
            OP_SHRA: begin sv = {b[DW-1], b[DW-1:1]};     sc = b[0];    end
            OP_SHRL: begin sv = {1'b0, b[DW-1:1]};        sc = b[0];    end
            OP_SWAP: begin sv = {b[NW-1:0], b[DW-1:NW]};  sc = 1'b0;    end
            default: ;
        endcase
    end

    always_comb begin
        res.val = b;
        res.wr  = 1'b0;
        res.f   = fin;
        case (op)
            OP_BTST: begin
                res.f.z = ((b & mask) == '0);
                res.f.n = 1'b0;
                res.f.h = 1'b1;
            end
            OP_BSET: begin
                res.val = b | mask;
                res.wr  = 1'b1;
            end
            OP_BCLR: begin
                res.val = b & ~mask;
                res.wr  = 1'b1;
            end
            default: begin
                res.val = sv;
                res.wr  = 1'b1;
                res.f   = '{z: (sv == '0), n: 1'b0, h: 1'b0, c: sc};
            end
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [4:0]    op_i,
    input  logic [7:0]    a_i,
    input  logic [7:0]    b_i,
    input  logic [2:0]    sel_i,
    input  logic [7:0]    flags_i,
    output logic [7:0]    result_o,
    output logic          wr_o,
    output logic [7:0]    flags_o
);

    alu_op_e  op;
    alu_cls_e cls;
    flags_t   fin;
    alu_res_t r_arith, r_logic, r_shift, r_sel;
    logic [DW-1:0] flag_q;

    assign op  = alu_op_e'(op_i);
    assign cls = op_class(op);
    assign fin = flags_from_byte(flags_i);

    alu_arith u_arith (
        .op  (op),
        .a   (a_i),
        .b   (b_i),
        .fin (fin),
        .res (r_arith)
    );

    alu_logic u_logic (
        .op  (op),
        .a   (a_i),
        .b   (b_i),
        .fin (fin),
        .res (r_logic)
    );

    alu_shifter u_shift (
        .op  (op),
        .b   (b_i),
        .sel (sel_i),
        .fin (fin),
        .res (r_shift)
    );

    always_comb begin
        case (cls)
            CLS_ARITH: r_sel = r_arith;
            CLS_LOGIC: r_sel = r_logic;
            CLS_SHIFT: r_sel = r_shift;
            default:   r_sel = '{val: a_i, wr: 1'b0, f: fin};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= flags_to_byte(r_sel.f);
    end

    assign result_o = r_sel.val;
    assign wr_o     = r_sel.wr;
    assign flags_o  = flag_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
    input logic       clk,
    input logic       rst,
    input logic [4:0] op_i,
    input logic [7:0] b_i,
    input logic [2:0] sel_i,
    input logic [7:0] flags_i,
    input logic       wr_o,
    input logic [7:0] flags_o
);

    AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (flags_o[3:0] == 4'h0)); // R1

    AST_NOP_PASSES_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (op_i == 5'd0 || op_i > 5'd25) |=> (flags_o[7:4] == $past(flags_i[7:4]))); // R1

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op_i == 5'd5) |-> !wr_o); // R3

    AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (rst)
        (op_i == 5'd9 || op_i == 5'd10) |=> (flags_o[4] == $past(flags_i[4]))); // R5

    AST_SCF_SETS_C: assert property (@(posedge clk) disable iff (rst)
        (op_i == 5'd12) |=> (flags_o[4] && !flags_o[6] && !flags_o[5])); // R7

    AST_BTST_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_i == 5'd22) |=> (flags_o[7] == !$past(b_i[sel_i]))); // R10

    AST_BSETCLR_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (op_i == 5'd23 || op_i == 5'd24) |=> (flags_o[7:4] == $past(flags_i[7:4]))); // R11

endmodule

bind acc_alu acc_alu_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op_i),
    .b_i     (b_i),
    .sel_i   (sel_i),
    .flags_i (flags_i),
    .wr_o    (wr_o),
    .flags_o (flags_o)
);

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_i = '0;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic [2:0] sel_i = '0;
    logic [7:0] flags_i = '0;
    logic [7:0] result_o;
    logic       wr_o;
    logic [7:0] flags_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    acc_alu dut (
        .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .sel_i(sel_i), .flags_i(flags_i), .result_o(result_o),
        .wr_o(wr_o), .flags_o(flags_o)
    );

    function automatic string req_of(int op);
        case (op)
            1, 2:              return "R2";
            3, 4, 5:           return "R3";
            6, 7, 8:           return "R4";
            9, 10:             return "R5";
            11:                return "R6";
            12, 13:            return "R7";
            14, 15, 16, 17:    return "R8";
            18, 19, 20, 21:    return "R9";
            22:                return "R10";
            23, 24:            return "R11";
            25:                return "R12";
            default:           return "R1";
        endcase
    endfunction

    // Returns {wr, value[7:0], flag byte[7:0]} from the requirement text.
    function automatic logic [16:0] model(int op, int a, int b, int idx, logic [7:0] fl);
        int z, n, h, c, v, w, t;
        z = fl[7]; n = fl[6]; h = fl[5]; c = fl[4];
        v = a; w = 1;
        case (op)
            1, 2: begin
                t = (op == 2) ? c : 0;
                v = a + b + t;
                h = ((a % 16) + (b % 16) + t) > 15;
                c = v > 255; v = v % 256; z = (v == 0); n = 0;
            end
            3, 4, 5: begin
                t = (op == 4) ? c : 0;
                v = a - b - t;
                h = ((a % 16) - (b % 16) - t) < 0;
                c = v < 0; v = (v + 256) % 256; z = (v == 0); n = 1;
                w = (op != 5);
            end
            6: begin v = a & b; z = (v == 0); n = 0; h = 1; c = 0; end
            7: begin v = a | b; z = (v == 0); n = 0; h = 0; c = 0; end
            8: begin v = a ^ b; z = (v == 0); n = 0; h = 0; c = 0; end
            9:  begin v = (b + 1) % 256; h = (b % 16) == 15; n = 0; z = (v == 0); end
            10: begin v = (b + 255) % 256; h = (b % 16) == 0; n = 1; z = (v == 0); end
            11: begin v = 255 - a; n = 1; h = 1; end
            12: begin w = 0; n = 0; h = 0; c = 1; end
            13: begin w = 0; n = 0; h = 0; c = 1 - c; end
            14: begin v = ((b * 2) % 256) + c;        c = b / 128; end
            15: begin v = ((b * 2) % 256) + b / 128;  c = b / 128; end
            16: begin v = b / 2 + c * 128;            c = b % 2; end
            17: begin v = b / 2 + (b % 2) * 128;      c = b % 2; end
            18: begin v = (b * 2) % 256;              c = b / 128; end
            19: begin v = b / 2 + (b / 128) * 128;    c = b % 2; end
            20: begin v = b / 2;                      c = b % 2; end
            21: begin v = (b % 16) * 16 + b / 16;     c = 0; end
            22: begin w = 0; z = ((b >> idx) % 2) == 0; n = 0; h = 1; end
            23: v = b | (1 << idx);
            24: v = b & ~(1 << idx) & 255;
            25: begin
                v = a;
                if (n == 0) begin
                    if (c == 1 || a > 153) begin v = v + 96; c = 1; end
                    if (h == 1 || (a % 16) > 9) v = v + 6;
                end else begin
                    if (c == 1) v = v - 96;
                    if (h == 1) v = v - 6;
                end
                v = (v + 512) % 256; z = (v == 0); h = 0;
            end
            default: w = 0;
        endcase
        if (op >= 14 && op <= 21) begin
            z = (v == 0); n = 0; h = 0;
        end
        if (op == 0 || op > 25) v = a;
        return {1'(w), 8'(v), 1'(z), 1'(n), 1'(h), 1'(c), 4'h0};
    endfunction

    task automatic run_vec(int op, int a, int b, int idx, logic [7:0] fl);
        logic [16:0] exp;
        @(negedge clk);
        op_i = 5'(op); a_i = 8'(a); b_i = 8'(b); sel_i = 3'(idx); flags_i = fl;
        exp = model(op, a, b, idx, fl);
        @(posedge clk);
        #1;
        n_chk++;
        if ((exp[16] == 1'b1 && result_o !== exp[15:8]) || wr_o !== exp[16] ||
            flags_o !== exp[7:0]) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%02h b=%02h sel=%0d fin=%02h: got res=%02h wr=%0b fl=%02h, expected res=%02h wr=%0b fl=%02h",
                     req_of(op), op, a, b, idx, fl, result_o, wr_o, flags_o,
                     exp[15:8], exp[16], exp[7:0]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(195000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if (flags_o !== 8'h00) begin
            n_bad++;
            $display("FAIL R1 reset flags: got %02h expected 00", flags_o);
        end
        @(negedge clk);
        rst = 1'b0;

        // Directed corners
        run_vec(1, 8'hFF, 8'h01, 0, 8'h00);   // R2 wrap to zero, H and C
        run_vec(2, 8'h0F, 8'h00, 0, 8'h10);   // R2 carry-in crosses nibble
        run_vec(3, 8'h10, 8'h01, 0, 8'h00);   // R3 half borrow
        run_vec(5, 8'h42, 8'h42, 0, 8'h00);   // R3 compare equal, no write
        run_vec(4, 8'h00, 8'h00, 0, 8'h10);   // R3 borrow from carry-in only
        run_vec(9, 0, 8'hFF, 0, 8'h10);       // R5 increment wraps, keep C=1
        run_vec(10, 0, 8'h00, 0, 8'h00);      // R5 decrement wraps, keep C=0
        run_vec(22, 0, 8'h7F, 7, 8'h10);      // R10 bit 7 clear
        run_vec(22, 0, 8'h01, 0, 8'h00);      // R10 bit 0 set
        run_vec(23, 0, 8'h00, 7, 8'hF0);      // R11 set msb, flags kept
        run_vec(24, 0, 8'hFF, 0, 8'h50);      // R11 clear lsb, flags kept
        run_vec(12, 0, 0, 0, 8'h80);          // R7 set carry keeps Z
        run_vec(13, 0, 0, 0, 8'hF0);          // R7 complement carry
        run_vec(11, 8'h5A, 0, 0, 8'h90);      // R6 complement
        run_vec(0, 8'h33, 8'h44, 0, 8'hB0);   // R1 no-op passes flags
        run_vec(31, 8'h33, 8'h44, 0, 8'h70);  // R1 unused code is a no-op
        run_vec(25, 8'h9A, 0, 0, 8'h00);      // R12 both corrections, C set
        run_vec(21, 0, 8'hF0, 0, 8'h10);      // R9 swap clears C
        run_vec(14, 0, 8'h80, 0, 8'h00);      // R8 rotate through carry to zero

        // Exhaustive add/subtract with carry (R2, R3)
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                run_vec(2, a, b, 0, {4'($urandom()), 4'h0});
                run_vec(4, a, b, 0, {4'($urandom()), 4'h0});
            end
        end

        // Decimal adjust over all A and all N/H/C (R12)
        for (int a = 0; a < 256; a++) begin
            for (int f = 0; f < 8; f++) begin
                run_vec(25, a, 0, 0, {1'($urandom()), 3'(f), 4'h0});
            end
        end

        // Single-operand ops over all operand values (R5, R8, R9)
        for (int op = 9; op <= 21; op++) begin
            if (op >= 11 && op <= 13) continue;
            for (int b = 0; b < 256; b++) begin
                run_vec(op, 0, b, 0, {4'($urandom()), 4'h0});
            end
        end

        // Constrained random over all codes (R1..R13)
        for (int k = 0; k < 15000; k++) begin
            run_vec(int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
                    int'($urandom_range(0, 255)), int'($urandom_range(0, 7)),
                    {4'($urandom()), 4'h0});
        end
        // R13 write-enable is compared in every vector above.

        finish_run();
    end

endmodule